// File: doc/BRIEF.md
# Multicast Address Filter Table

This block decides whether a received frame is kept, based on its 48-bit destination address. It holds a small table of multicast addresses. When filtering is active, a destination address passes only if it equals one of the non-zero table entries or is the all-ones broadcast address. A promiscuous control turns the filter off, and every frame then passes.

Software reaches the table indirectly through three host registers. It first loads the low 32 bits of an address into one staging word. It then writes a second word that carries the upper 16 bits, an entry selector and a read-not-write command. A write command stores the staged address into the selected entry one cycle later. A read command copies the selected entry back into both staging words one cycle later, so that host reads can return it.

The receive path presents an address together with a valid strobe. The registered decision appears one clock later. Reset is asserted asynchronously and released synchronously inside the block. The reset value of the promiscuous control is taken from a static configuration pin.

Top module: `mcf_filter`

## Requirements
- R1: After reset the low staging word, the upper staging bits, the selector and the command bit all read as zero. The promiscuous bit reads 1 when `cfg_promisc_off` is 0 and reads 0 when it is 1. Every table entry is zero.
- R2: A host write to offset 0x388 stores all 32 bits into the low staging word. A host read of 0x388 returns that word.
- R3: Offset 0x38C holds the following fields: address bits [47:32] in bits [15:0], the entry selector in bits [17:16] (code n selects entry n, for n = 0 to 3), and the read-not-write command in bit [23]. Bits [22:18] and [31:24] always read as zero, whatever was written to them.
- R4: A write to 0x38C with bit [23] = 0 stores the 48-bit staged address (upper bits from that same write, lower bits from 0x388) into the selected entry on the following clock edge. No other entry changes.
- R5: A write to 0x38C with bit [23] = 1 copies the selected entry into both staging words on the following clock edge. Later reads of 0x388 and 0x38C then return the entry.
- R6: Bit [31] of offset 0x390 is the promiscuous bit and can be written and read. Bits [30:0] of that offset read as zero.
- R7: While the promiscuous bit is 1, every destination address is accepted.
- R8: While the filter is active, an address that exactly equals a non-zero entry is accepted. An address that differs from every entry in at least one bit, and is not broadcast, is rejected.
- R9: The all-ones broadcast address is always accepted.
- R10: An all-zero entry never produces a match. While the filter is active, the all-zero address is rejected.
- R11: `flt_vld` is 1 in exactly the cycle after each `rx_da_vld` cycle. `flt_accept` is 0 whenever `flt_vld` is 0.
- R12: A host read returns data in `host_rdata` one clock after `host_rd`. Offsets other than 0x388, 0x38C and 0x390 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_promisc_off | input | 1 | Static pin; 1 makes the promiscuous bit reset to 0 |
| host_we | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 12 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid one cycle after host_rd |
| rx_da | input | 48 | Destination address under test |
| rx_da_vld | input | 1 | Destination address valid strobe |
| flt_vld | output | 1 | Filter decision valid |
| flt_accept | output | 1 | 1 = accept frame, 0 = reject |

## Verification
The assertions assume that `cfg_promisc_off` stays constant while reset is released. They also assume that `host_rd` and `host_we` are never raised in the same cycle. The stimulus holds the configuration pin steady, changing it only while `rst_n` is low. Each host access is a single strobe that is lowered before the next one starts. A table command is always followed by one idle cycle, so the copy or the store completes before the next host access or lookup.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
  parameter int MAC_W    = 48;
  parameter int DATA_W   = 32;
  parameter int ADDR_W   = 12;
  parameter int N_ENT    = 4;
  parameter int SEL_W    = $clog2(N_ENT);
  parameter int HI_W     = MAC_W - DATA_W;

  parameter logic [ADDR_W-1:0] OFS_STAGE_LO = 12'h388;
  parameter logic [ADDR_W-1:0] OFS_STAGE_HI = 12'h38C;
  parameter logic [ADDR_W-1:0] OFS_MODE     = 12'h390;

  parameter int SEL_LSB  = 16;
  parameter int RNW_BIT  = 23;
  parameter int PROM_BIT = 31;

  typedef logic [MAC_W-1:0] mac_t;
endpackage

// File: rtl/mcf_rst_sync.sv
module mcf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/mcf_host_regs.sv
module mcf_host_regs
  import mcf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_promisc_off,
  input  logic              host_we,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  mac_t              entry_rd,
  output mac_t              stage_addr,
  output logic [SEL_W-1:0]  sel,
  output logic              tbl_wr,
  output logic              promisc
);
  logic [DATA_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic              rnw_q, rnw_d;
  logic              go_q, go_d;
  logic              prom_q, prom_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] hi_word;
  logic [DATA_W-1:0] mode_word;
  logic              hit_lo, hit_hi, hit_mode;

  assign hit_lo   = (host_addr == OFS_STAGE_LO);
  assign hit_hi   = (host_addr == OFS_STAGE_HI);
  assign hit_mode = (host_addr == OFS_MODE);

  // Read views: reserved bits stay zero
  always_comb begin
    hi_word = '0;
    hi_word[HI_W-1:0] = hi_q;
    hi_word[SEL_LSB +: SEL_W] = sel_q;
    hi_word[RNW_BIT] = rnw_q;
    mode_word = '0;
    mode_word[PROM_BIT] = prom_q;
  end

  // Next state
  always_comb begin
    lo_d    = lo_q;
    hi_d    = hi_q;
    sel_d   = sel_q;
    rnw_d   = rnw_q;
    prom_d  = prom_q;
    go_d    = 1'b0;
    rdata_d = rdata_q;

    // Completion of a pending read command
    if (go_q && rnw_q) begin
      lo_d = entry_rd[DATA_W-1:0];
      hi_d = entry_rd[MAC_W-1:DATA_W];
    end

    if (host_we) begin
      if (hit_lo) begin
        lo_d = host_wdata;
      end
      if (hit_hi) begin
        hi_d  = host_wdata[HI_W-1:0];
        sel_d = host_wdata[SEL_LSB +: SEL_W];
        rnw_d = host_wdata[RNW_BIT];
        go_d  = 1'b1;
      end
      if (hit_mode) begin
        prom_d = host_wdata[PROM_BIT];
      end
    end

    if (host_rd) begin
      if (hit_lo) begin
        rdata_d = lo_q;
      end else if (hit_hi) begin
        rdata_d = hi_word;
      end else if (hit_mode) begin
        rdata_d = mode_word;
      end else begin
        rdata_d = '0;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      sel_q   <= '0;
      rnw_q   <= 1'b0;
      go_q    <= 1'b0;
      prom_q  <= ~cfg_promisc_off;
      rdata_q <= '0;
    end else begin
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      sel_q   <= sel_d;
      rnw_q   <= rnw_d;
      go_q    <= go_d;
      prom_q  <= prom_d;
      rdata_q <= rdata_d;
    end
  end

  assign host_rdata = rdata_q;
  assign stage_addr = {hi_q, lo_q};
  assign sel        = sel_q;
  assign tbl_wr     = go_q & ~rnw_q;
  assign promisc    = prom_q;
endmodule

// File: rtl/mcf_table.sv
module mcf_table
  import mcf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [SEL_W-1:0]       sel,
  input  mac_t                   wdata,
  output mac_t                   rdata,
  output logic [N_ENT-1:0][MAC_W-1:0] entries
);
  logic [N_ENT-1:0][MAC_W-1:0] ent_q;
  logic [N_ENT-1:0][MAC_W-1:0] ent_d;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic we_g;
    assign we_g = wr && (sel == SEL_W'(g));

    always_comb begin
      ent_d[g] = ent_q[g];
      if (we_g) begin
        ent_d[g] = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else if (we_g) begin
        ent_q[g] <= ent_d[g];
      end
    end
  end

  assign rdata   = ent_q[sel];
  assign entries = ent_q;
endmodule

// File: rtl/mcf_match.sv
module mcf_match
  import mcf_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        promisc,
  input  logic [N_ENT-1:0][MAC_W-1:0] entries,
  input  mac_t                        rx_da,
  input  logic                        rx_da_vld,
  output logic                        flt_vld,
  output logic                        flt_accept
);
  logic [N_ENT-1:0] hit;
  logic             bcast;
  logic             pass;
  logic             vld_q, vld_d;
  logic             acc_q, acc_d;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    logic used;
    assign used   = |entries[g];
    assign hit[g] = used && (entries[g] == rx_da);
  end

  assign bcast = &rx_da;
  assign pass  = promisc | bcast | (|hit);

  always_comb begin
    vld_d = rx_da_vld;
    acc_d = rx_da_vld & pass;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      acc_q <= acc_d;
    end
  end

  assign flt_vld    = vld_q;
  assign flt_accept = acc_q;
endmodule

// File: rtl/mcf_filter.sv
module mcf_filter
  import mcf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_promisc_off,
  input  logic              host_we,
  input  logic              host_rd,
  input  logic [11:0]       host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic [47:0]       rx_da,
  input  logic              rx_da_vld,
  output logic              flt_vld,
  output logic              flt_accept
);
  logic                        rst_sync_n;
  mac_t                        stage_addr;
  mac_t                        entry_rd;
  logic [SEL_W-1:0]            sel;
  logic                        tbl_wr;
  logic                        promisc;
  logic [N_ENT-1:0][MAC_W-1:0] entries;

  mcf_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mcf_host_regs u_regs (
    .clk             (clk),
    .rst_n           (rst_sync_n),
    .cfg_promisc_off (cfg_promisc_off),
    .host_we         (host_we),
    .host_rd         (host_rd),
    .host_addr       (host_addr),
    .host_wdata      (host_wdata),
    .host_rdata      (host_rdata),
    .entry_rd        (entry_rd),
    .stage_addr      (stage_addr),
    .sel             (sel),
    .tbl_wr          (tbl_wr),
    .promisc         (promisc)
  );

  mcf_table u_tbl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr      (tbl_wr),
    .sel     (sel),
    .wdata   (stage_addr),
    .rdata   (entry_rd),
    .entries (entries)
  );

  mcf_match u_match (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .promisc    (promisc),
    .entries    (entries),
    .rx_da      (rx_da),
    .rx_da_vld  (rx_da_vld),
    .flt_vld    (flt_vld),
    .flt_accept (flt_accept)
  );
endmodule

// File: rtl/mcf_filter_chk.sv
module mcf_filter_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        promisc,
  input logic        host_rd,
  input logic [11:0] host_addr,
  input logic [31:0] host_rdata,
  input logic [47:0] rx_da,
  input logic        rx_da_vld,
  input logic        flt_vld,
  input logic        flt_accept
);
  assert_vld_follows_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_da_vld |=> flt_vld);

  assert_vld_quiet_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rx_da_vld |=> (!flt_vld && !flt_accept));

  assert_promisc_accept_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_da_vld && promisc) |=> flt_accept);

  assert_bcast_accept_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_da_vld && (&rx_da)) |=> flt_accept);

  assert_zero_reject_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_da_vld && (rx_da == '0) && !promisc) |=> !flt_accept);

  assert_resv_zero_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_rd && (host_addr == 12'h38C)) |=> ((host_rdata[31:24] == '0) && (host_rdata[22:18] == '0)));

  assert_mode_resv_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_rd && (host_addr == 12'h390)) |=> (host_rdata[30:0] == '0));
endmodule

bind mcf_filter mcf_filter_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .promisc    (promisc),
  .host_rd    (host_rd),
  .host_addr  (host_addr),
  .host_rdata (host_rdata),
  .rx_da      (rx_da),
  .rx_da_vld  (rx_da_vld),
  .flt_vld    (flt_vld),
  .flt_accept (flt_accept)
);

// File: tb/sim_mcf_filter.sv
`timescale 1ns/1ps
module sim_mcf_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_promisc_off;
  logic        host_we, host_rd;
  logic [11:0] host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic [47:0] rx_da;
  logic        rx_da_vld;
  logic        flt_vld, flt_accept;

  int checks = 0;
  int errors = 0;
  logic [47:0] model [4];
  logic        m_prom;

  always #2 clk = ~clk;

  mcf_filter u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    tick();
    host_we = 1'b0;
  endtask

  task automatic hread(input logic [11:0] a, output logic [31:0] d);
    host_addr = a; host_rd = 1'b1;
    tick();
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  function automatic logic [31:0] hi_word(input int sel, input bit rnw, input logic [15:0] hi);
    logic [31:0] w;
    w = '0;
    w[15:0] = hi;
    w[17:16] = 2'(sel);
    w[23] = rnw;
    return w;
  endfunction

  task automatic write_entry(input int i, input logic [47:0] v);
    hwrite(12'h388, v[31:0]);
    hwrite(12'h38C, hi_word(i, 1'b0, v[47:32]));
    tick();
    model[i] = v;
  endtask

  task automatic check_entry(input int i, input string req);
    logic [31:0] d;
    hwrite(12'h38C, hi_word(i, 1'b1, 16'h0));
    tick();
    hread(12'h388, d);
    chk(d == model[i][31:0], req, d, model[i][31:0]);
    hread(12'h38C, d);
    chk(d == hi_word(i, 1'b1, model[i][47:32]), req, d, hi_word(i, 1'b1, model[i][47:32]));
  endtask

  function automatic bit exp_accept(input logic [47:0] da);
    bit r;
    r = m_prom || (&da);
    for (int k = 0; k < 4; k++) if (model[k] != '0 && model[k] == da) r = 1'b1;
    return r;
  endfunction

  task automatic lookup(input logic [47:0] da, input string req);
    bit e;
    e = exp_accept(da);
    rx_da = da; rx_da_vld = 1'b1;
    tick();
    rx_da_vld = 1'b0;
    chk(flt_vld == 1'b1, "R11", flt_vld, 1);
    chk(flt_accept == e, req, flt_accept, e);
  endtask

  task automatic do_reset(input bit cfg);
    rst_n = 1'b0; cfg_promisc_off = cfg;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    for (int k = 0; k < 4; k++) model[k] = '0;
    m_prom = ~cfg;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [47:0] v;
    host_we = 0; host_rd = 0; host_addr = '0; host_wdata = '0;
    rx_da = '0; rx_da_vld = 0;

    // R1 with configuration 1 -> promiscuous off
    do_reset(1'b1);
    chk(flt_vld == 0 && flt_accept == 0, "R1", {flt_vld, flt_accept}, 0);
    hread(12'h388, d); chk(d == 0, "R1", d, 0);
    hread(12'h38C, d); chk(d == 0, "R1", d, 0);
    hread(12'h390, d); chk(d == 0, "R1", d, 0);
    for (int i = 0; i < 4; i++) check_entry(i, "R1");

    // R2 low staging word
    hwrite(12'h388, 32'hDEAD_BEEF);
    hread(12'h388, d); chk(d == 32'hDEAD_BEEF, "R2", d, 32'hDEAD_BEEF);
    // R3 reserved bits dropped
    hwrite(12'h38C, 32'hFFFF_FFFF);
    tick();
    hread(12'h38C, d); chk(d == 32'h00_8_3_0000 | (d & 32'hFFFF) , "R3", d, 32'h0083_0000);
    chk(d[31:24] == 0 && d[22:18] == 0, "R3", d, 32'h0083_0000);
    // R6 mode reserved bits
    hwrite(12'h390, 32'h7FFF_FFFF);
    hread(12'h390, d); chk(d == 0, "R6", d, 0);
    hwrite(12'h390, 32'hFFFF_FFFF);
    hread(12'h390, d); chk(d == 32'h8000_0000, "R6", d, 32'h8000_0000);
    m_prom = 1'b1;
    lookup(48'h1234_5678_9ABC, "R7");
    lookup(48'h0, "R7");
    hwrite(12'h390, 32'h0);
    m_prom = 1'b0;
    hread(12'h390, d); chk(d == 0, "R6", d, 0);

    // R10 empty table: zero rejected, R9 broadcast accepted
    lookup(48'h0, "R10");
    lookup(48'hFFFF_FFFF_FFFF, "R9");

    // R4 fill entries 0..2, leave 3 empty
    for (int i = 0; i < 3; i++) write_entry(i, 48'h0100_5E00_0000 + 48'(i) * 48'h0001_0203_0405);
    for (int i = 0; i < 4; i++) check_entry(i, "R4");
    lookup(48'h0, "R10");

    // R8 exact match and single-bit neighbours
    for (int i = 0; i < 3; i++) begin
      lookup(model[i], "R8");
      for (int b = 0; b < 48; b++) begin
        v = model[i];
        v[b] = ~v[b];
        lookup(v, "R8");
      end
    end

    // R11 strobe quiet afterwards
    tick();
    chk(flt_vld == 0 && flt_accept == 0, "R11", {flt_vld, flt_accept}, 0);

    // R4 overwrite entry 1, old value now rejected; fill entry 3
    v = model[1];
    write_entry(1, 48'h3333_0000_0001);
    lookup(v, "R4");
    lookup(48'h3333_0000_0001, "R4");
    write_entry(3, 48'hFFFF_FFFF_FFFE);
    for (int i = 0; i < 4; i++) check_entry(i, "R5");

    // R5 read copy replaces staging
    hwrite(12'h388, 32'h5555_5555);
    hwrite(12'h38C, hi_word(3, 1'b1, 16'h0));
    tick();
    hread(12'h388, d); chk(d == model[3][31:0], "R5", d, model[3][31:0]);

    // R12 unmapped offsets
    hwrite(12'h394, 32'hFFFF_FFFF);
    hwrite(12'h384, 32'hFFFF_FFFF);
    hread(12'h394, d); chk(d == 0, "R12", d, 0);
    hread(12'h390, d); chk(d == 0, "R12", d, 0);
    hread(12'h388, d); chk(d == model[3][31:0], "R12", d, model[3][31:0]);
    for (int i = 0; i < 4; i++) check_entry(i, "R12");

    // R1 with configuration 0 -> promiscuous on, table cleared
    do_reset(1'b0);
    hread(12'h390, d); chk(d == 32'h8000_0000, "R1", d, 32'h8000_0000);
    for (int i = 0; i < 4; i++) check_entry(i, "R1");
    lookup(48'h0, "R7");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule